// File: doc/BRIEF.md
# Event Readout Collector Controller

This block is the collecting end of a trigger-driven readout link. A front-end card raises a readout request. The collector then drives a read-enable toward the card and moves 32-bit words from the card into a local FIFO. Each word uses a four-phase handshake: the card raises data-ready with a word on its data lines, and the collector writes that word into the local FIFO and raises data-ack. The card then drops data-ready, and the collector drops data-ack. When the card raises its chained end-of-readout line, the collector sends a one-cycle readout-complete pulse back to the card. It removes read-enable at the same time and moves on to the next 4-bit event number.

Every control line from the card is asynchronous and passes through a two-flop synchronizer before use. The data lines are bundled with data-ready. The card holds them stable while data-ready is high, so they are used without synchronizing. The local FIFO port is a valid/ready stream in which the collector is the source. Valid is raised only while a synchronized data-ready is pending, and it never depends on ready. A word moves on a clock edge where valid and ready are both high. While ready is low (FIFO full), valid and the word stay in place, and data-ack is withheld, so the card simply waits. A front-end source FIFO holds up to 1024 words per event.

Top module: `readout_collector`

## Requirements
- R1: After reset, `fe_read_en_o`, `fe_ack_o`, `fe_done_o` and `wr_valid_o` are low and `evt_num_o` is 0.
- R2: A low-to-high change of `fe_start_i` raises `fe_read_en_o` exactly three clock edges later. The edges are counted from the first edge that samples the new level.
- R3: While read-enable is high, each assertion of `fe_ready_i` produces exactly one stream transfer carrying `fe_data_i`. `fe_ack_o` rises on the edge after that transfer, which is three edges after `fe_ready_i` rises when the FIFO has room. The words of an event arrive in order and none is dropped or repeated.
- R4: `fe_ack_o` stays high for as long as `fe_ready_i` stays high, and no transfer occurs meanwhile. It falls three edges after `fe_ready_i` falls.
- R5: While `wr_ready_i` is low, no transfer occurs and `fe_ack_o` stays low, with `wr_valid_o` held. When `wr_ready_i` returns high, the transfer happens on the next edge and `fe_ack_o` is high after that edge.
- R6: A rising `fe_end_i` produces a `fe_done_o` pulse of exactly one cycle, three edges later. `fe_read_en_o` is low during the pulse and afterwards.
- R7: `evt_num_o` increases by one, modulo 16, on the edge that ends each `fe_done_o` pulse.
- R8: A `fe_start_i` level held high does not start a new readout after `fe_done_o`; only a fresh rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_start_i | input | 1 | Readout request from the front end (asynchronous) |
| fe_ready_i | input | 1 | Word present on `fe_data_i` (asynchronous) |
| fe_end_i | input | 1 | Chained end-of-readout from the front end (asynchronous) |
| fe_data_i | input | 32 | Word from the front end, stable while `fe_ready_i` is high |
| fe_read_en_o | output | 1 | Read-enable toward the front end |
| fe_ack_o | output | 1 | Word acknowledge toward the front end |
| fe_done_o | output | 1 | One-cycle readout-complete reset pulse |
| evt_num_o | output | 4 | Current event number |
| wr_valid_o | output | 1 | Stream valid toward the local FIFO |
| wr_ready_i | input | 1 | Stream ready from the local FIFO (low when full) |
| wr_data_o | output | 32 | Stream word toward the local FIFO |

## Verification
A controller stuck in its acknowledge phase shows up as `fe_ack_o` failing to fall within three edges of data-ready falling. A controller that leaves that phase too early shows up as a second stream transfer for a single word, and the word-by-word data comparison catches it at once. A broken launch or completion path moves the three-edge latency of `fe_read_en_o` or `fe_done_o`, or leaves read-enable high after the pulse. A wrong event counter appears at the end of each event as an `evt_num_o` that is off by one, and sweeping past sixteen events exposes any fault in its wrap.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned EVT_W  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2,
    ST_DONE = 2'd3
  } rc_state_e;
endpackage

// File: rtl/rc_sync.sv
module rc_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/rc_fsm.sv
module rc_fsm
  import rc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_s,
  input  logic ready_s,
  input  logic end_s,
  input  logic wr_ready_i,
  output logic wr_valid_o,
  output logic read_en_o,
  output logic ack_o,
  output logic done_o
);
  rc_state_e state_q, state_d;
  logic      start_q;
  logic      launch;

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_s;
  end

  assign launch = start_s && !start_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (launch) state_d = ST_WAIT;
      ST_WAIT: begin
        if (end_s)                        state_d = ST_DONE;
        else if (ready_s && wr_ready_i)   state_d = ST_ACK;
      end
      ST_ACK:  if (!ready_s) state_d = ST_WAIT;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign read_en_o  = (state_q == ST_WAIT) || (state_q == ST_ACK);
  assign ack_o      = (state_q == ST_ACK);
  assign done_o     = (state_q == ST_DONE);
  assign wr_valid_o = (state_q == ST_WAIT) && ready_s && !end_s;

  AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(wr_valid_o && wr_ready_i)); // R3
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o && ready_s |=> ack_o); // R4
  AST_FULL_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> !ack_o && wr_valid_o); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_DONE_RE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !read_en_o); // R6
  AST_LAUNCH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_en_o) |-> start_s); // R2
endmodule

// File: rtl/rc_evt_cnt.sv
module rc_evt_cnt #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [WIDTH-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      count_o <= '0;
    else if (step_i) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/readout_collector.sv
module readout_collector
  import rc_pkg::*;
#(
  parameter int unsigned DW          = DATA_W,
  parameter int unsigned EW          = EVT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fe_start_i,
  input  logic          fe_ready_i,
  input  logic          fe_end_i,
  input  logic [DW-1:0] fe_data_i,
  output logic          fe_read_en_o,
  output logic          fe_ack_o,
  output logic          fe_done_o,
  output logic [EW-1:0] evt_num_o,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [DW-1:0] wr_data_o
);
  localparam int unsigned NCTL = 3;

  logic [NCTL-1:0] ctl_s;
  logic            done;

  rc_sync #(.WIDTH(NCTL), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({fe_end_i, fe_ready_i, fe_start_i}),
    .sync_o  (ctl_s)
  );

  rc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_s    (ctl_s[0]),
    .ready_s    (ctl_s[1]),
    .end_s      (ctl_s[2]),
    .wr_ready_i (wr_ready_i),
    .wr_valid_o (wr_valid_o),
    .read_en_o  (fe_read_en_o),
    .ack_o      (fe_ack_o),
    .done_o     (done)
  );

  rc_evt_cnt #(.WIDTH(EW)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (done),
    .count_o (evt_num_o)
  );

  assign fe_done_o = done;
  assign wr_data_o = fe_data_i;

  AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fe_done_o |=> evt_num_o == $past(evt_num_o) + 1'b1); // R7
  AST_EVT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fe_done_o |=> $stable(evt_num_o)); // R7
endmodule

// File: tb/readout_collector_tb.sv
module readout_collector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fe_start_i = 1'b0, fe_ready_i = 1'b0, fe_end_i = 1'b0;
  logic [31:0] fe_data_i = '0;
  logic        fe_read_en_o, fe_ack_o, fe_done_o, wr_valid_o;
  logic        wr_ready_i = 1'b1;
  logic [3:0]  evt_num_o;
  logic [31:0] wr_data_o;

  int checks = 0;
  int errors = 0;
  int cur_evt = 0;
  int widx = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  readout_collector u_dut (
    .clk(clk), .rst_n(rst_n), .fe_start_i(fe_start_i), .fe_ready_i(fe_ready_i),
    .fe_end_i(fe_end_i), .fe_data_i(fe_data_i), .fe_read_en_o(fe_read_en_o),
    .fe_ack_o(fe_ack_o), .fe_done_o(fe_done_o), .evt_num_o(evt_num_o),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_data_o(wr_data_o)
  );

  function automatic logic [31:0] pat(input int e, input int i);
    return (32'(e) * 32'h0100_0193) ^ (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stream monitor: transfer happens on the edge after a negedge with valid&&ready
  always @(negedge clk) begin
    if (rst_n && wr_valid_o && wr_ready_i) begin
      check(wr_data_o == pat(cur_evt, widx), "R3 word", wr_data_o, pat(cur_evt, widx));
      widx++;
    end
  end

  task automatic wait_level(ref logic sig, input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sig !== lvl && n < 50);
  endtask

  task automatic send_word(input int i, input int hold, input bit full);
    int n;
    int w0;
    @(negedge clk);
    fe_data_i = pat(cur_evt, i);
    fe_ready_i = 1'b1;
    if (full) begin
      wr_ready_i = 1'b0;
      w0 = widx;
      repeat (10) @(negedge clk);
      check(fe_ack_o == 1'b0, "R5 ack withheld", fe_ack_o, 0);
      check(widx == w0, "R5 no write", widx, w0);
      check(wr_valid_o == 1'b1, "R5 valid held", wr_valid_o, 1);
      wr_ready_i = 1'b1;
      @(negedge clk);
      check(fe_ack_o == 1'b1, "R5 ack after space", fe_ack_o, 1);
    end else begin
      wait_level(fe_ack_o, 1'b1, n);
      check(n == 3, "R3 ack latency", n, 3);
    end
    w0 = widx;
    repeat (hold) @(negedge clk);
    check(fe_ack_o == 1'b1 && widx == w0, "R4 ack held", fe_ack_o, 1);
    fe_ready_i = 1'b0;
    wait_level(fe_ack_o, 1'b0, n);
    check(n == 3, "R4 ack release", n, 3);
  endtask

  task automatic run_event(input int nwords, input bit full_at1, input bit keep_start);
    int n;
    logic [3:0] ev0;
    widx = 0;
    @(negedge clk);
    fe_start_i = 1'b1;
    wait_level(fe_read_en_o, 1'b1, n);
    check(n == 3, "R2 read-enable latency", n, 3);
    for (int i = 0; i < nwords; i++) send_word(i, i % 3, full_at1 && i == 1);
    check(widx == nwords, "R3 word count", widx, nwords);
    ev0 = evt_num_o;
    @(negedge clk);
    fe_end_i = 1'b1;
    if (!keep_start) fe_start_i = 1'b0;
    wait_level(fe_done_o, 1'b1, n);
    check(n == 3, "R6 done latency", n, 3);
    check(fe_read_en_o == 1'b0, "R6 read-enable low at pulse", fe_read_en_o, 0);
    @(negedge clk);
    check(fe_done_o == 1'b0, "R6 single pulse", fe_done_o, 0);
    check(fe_read_en_o == 1'b0, "R6 read-enable low after", fe_read_en_o, 0);
    check(evt_num_o == ev0 + 4'd1, "R7 event number", evt_num_o, ev0 + 4'd1);
    fe_end_i = 1'b0;
    if (keep_start) begin
      repeat (10) @(negedge clk);
      check(fe_read_en_o == 1'b0, "R8 no relaunch", fe_read_en_o, 0);
      fe_start_i = 1'b0;
    end
    repeat (6) @(negedge clk);
    cur_evt++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(fe_read_en_o == 0 && fe_ack_o == 0 && fe_done_o == 0 && wr_valid_o == 0,
          "R1 outputs idle", {fe_read_en_o, fe_ack_o, fe_done_o, wr_valid_o}, 0);
    check(evt_num_o == 0, "R1 event number", evt_num_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int e = 0; e < 18; e++) run_event(e % 6, e == 2, e == 4 || e == 11);
    check(evt_num_o == 4'd2, "R7 wrap", evt_num_o, 2);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule